// File: doc/BRIEF.md
# Credit-Counting Virtual-Channel Link Transmitter

This block drives the transmit end of a point-to-point link whose receiver holds a separate input buffer for each virtual channel. For every channel the transmitter keeps a count of the free flit slots it believes the far buffer still has. Sending a flit on a channel uses up one of that channel's slots. A credit handed back by the receiver restores one slot for the channel it names. Because a flit only leaves when a slot is known to be free, the link never drops a flit.

Each channel offers packets flit by flit, with head and tail markers on the flits. Only one packet owns the link at a time. When the link is free, a round-robin arbiter picks among the channels whose head flit passes admission. The winner then keeps the link until its tail flit has gone. Admission depends on a mode input. In wormhole mode a head needs only one slot. In cut-through mode a head needs as many slots as the largest allowed packet, so the transmitter never has to know the real length of a packet.

The flit output is combinational from the chosen channel's input in the same cycle. The credit counters are registered.

Top module: `credit_vc_link_tx`

## Requirements
- R1: After reset every channel's counter holds BUF_DEPTH. With no credits returned, exactly BUF_DEPTH flits can leave on a channel before it stalls. A channel whose counter is zero does not admit a head flit.
- R2: A flit sent on one channel consumes a slot of that channel only. Other channels keep their counts and stay free to send.
- R3: A credit (crd_valid_i with crd_vc_i = v) raises channel v's count by one from the next cycle on. A stalled channel resumes in the cycle after the return. No counter ever goes below zero or above BUF_DEPTH.
- R4: With mode_i = 0 (wormhole), a head flit is admitted when its channel has at least one slot.
- R5: With mode_i = 1 (cut-through), a head flit is admitted only when its channel has at least MAX_PKT slots, even if the packet is shorter.
- R6: Once a head flit without a tail marker has been sent, only that channel's flits leave until its tail flit is sent. The packet stalls flit by flit while its channel has zero slots, and no other channel's head is sent in between.
- R7: A credit return and a flit send on the same channel in the same cycle leave that channel's count unchanged.
- R8: When the link is free and several heads are admissible, the grant goes to the first requester at or after the channel that follows the last channel granted a head, in ascending order with wrap-around. After reset the search starts at channel 0.
- R9: When a flit leaves, out_valid_o is 1 in the same cycle that in_ready_o of its channel is 1. out_vc_o gives the channel number, and out_data_o, out_head_o and out_tail_o carry that channel's input flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Admission rule: 0 wormhole, 1 cut-through |
| in_valid_i | input | NUM_VC | Per-channel flit valid |
| in_head_i | input | NUM_VC | Per-channel head marker |
| in_tail_i | input | NUM_VC | Per-channel tail marker |
| in_data_i | input | NUM_VC x FLIT_W | Per-channel flit payload |
| in_ready_o | output | NUM_VC | Flit of that channel is taken this cycle |
| out_valid_o | output | 1 | Flit on the link this cycle |
| out_vc_o | output | VC_W | Channel tag of the outgoing flit |
| out_head_o | output | 1 | Outgoing flit is a head |
| out_tail_o | output | 1 | Outgoing flit is a tail |
| out_data_o | output | FLIT_W | Outgoing payload |
| crd_valid_i | input | 1 | A credit is returned this cycle |
| crd_vc_i | input | VC_W | Channel the credit belongs to |

## Verification
A flit presented on an input reaches the link in the same cycle, so the bench drives inputs just after the falling edge and samples the output 1 ns later, before the next rising edge. A returned credit lands in its counter on the next rising edge. The bench therefore expects a stalled channel to move in the cycle after the return, never in the return cycle itself. The arbiter pointer and the counters change only at rising edges. Each expected grant order and stall point is derived from the sequence of heads and credits applied in earlier cycles.

// File: rtl/credit_vc_pkg.sv
`timescale 1ns/1ps
package credit_vc_pkg;
  typedef enum logic {
    ADMIT_WORMHOLE    = 1'b0,
    ADMIT_CUT_THROUGH = 1'b1
  } admit_mode_e;
endpackage

// File: rtl/vc_credit_ctr.sv
`timescale 1ns/1ps
module vc_credit_ctr #(
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             send_i,
  input  logic             ret_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(DEPTH);
    end else begin
      unique case ({send_i, ret_i})
        2'b10:   cnt_q <= cnt_q - 1'b1;
        2'b01:   cnt_q <= cnt_q + 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_i |-> cnt_q != '0);
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !send_i) |-> cnt_q < CNT_W'(DEPTH));
  assert_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_send_and_return_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_i && ret_i) |=> $stable(cnt_q));
endmodule

// File: rtl/vc_rr_arb.sv
`timescale 1ns/1ps
module vc_rr_arb #(
  parameter int N     = 4,
  parameter int PTR_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] win_idx;
  logic             found;

  always_comb begin
    gnt_o   = '0;
    win_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = (int'(ptr_q) + i) % N;
      if (!found && req_i[k]) begin
        found    = 1'b1;
        gnt_o[k] = 1'b1;
        win_idx  = PTR_W'(k);
      end
    end
  end

  // pointer moves past the winner only when its head actually leaves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (adv_i && found) begin
      ptr_q <= PTR_W'((int'(win_idx) + 1) % N);
    end
  end

  assert_grant_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_grant_needs_request_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/credit_vc_link_tx.sv
`timescale 1ns/1ps
module credit_vc_link_tx
  import credit_vc_pkg::*;
#(
  parameter int NUM_VC    = 4,
  parameter int FLIT_W    = 16,
  parameter int BUF_DEPTH = 6,
  parameter int MAX_PKT   = 4,
  parameter int VC_W      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mode_i,
  input  logic [NUM_VC-1:0]             in_valid_i,
  input  logic [NUM_VC-1:0]             in_head_i,
  input  logic [NUM_VC-1:0]             in_tail_i,
  input  logic [NUM_VC-1:0][FLIT_W-1:0] in_data_i,
  output logic [NUM_VC-1:0]             in_ready_o,
  output logic                          out_valid_o,
  output logic [VC_W-1:0]               out_vc_o,
  output logic                          out_head_o,
  output logic                          out_tail_o,
  output logic [FLIT_W-1:0]             out_data_o,
  input  logic                          crd_valid_i,
  input  logic [VC_W-1:0]               crd_vc_i
);
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic [CNT_W-1:0]  cnt    [NUM_VC];
  logic [NUM_VC-1:0] send;
  logic [NUM_VC-1:0] ret;
  logic [NUM_VC-1:0] has_one;
  logic [NUM_VC-1:0] admit;
  logic [NUM_VC-1:0] req;
  logic [NUM_VC-1:0] gnt;
  logic              busy_q;
  logic [VC_W-1:0]   owner_q;
  logic [VC_W-1:0]   sel;
  logic [VC_W-1:0]   gnt_idx;
  logic              fire;
  admit_mode_e       mode;

  assign mode = admit_mode_e'(mode_i);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vc_credit_ctr #(.DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .send_i (send[v]),
      .ret_i  (ret[v]),
      .cnt_o  (cnt[v])
    );
    assign has_one[v] = (cnt[v] != '0);
    assign admit[v]   = (mode == ADMIT_CUT_THROUGH) ? (cnt[v] >= CNT_W'(MAX_PKT)) : has_one[v];
    assign req[v]     = !busy_q && in_valid_i[v] && in_head_i[v] && admit[v];
    assign ret[v]     = crd_valid_i && (crd_vc_i == VC_W'(v));
    assign send[v]    = fire && (sel == VC_W'(v));
  end

  vc_rr_arb #(.N(NUM_VC), .PTR_W(VC_W)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .adv_i  (fire && !busy_q),
    .gnt_o  (gnt)
  );

  always_comb begin
    gnt_idx = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (gnt[v]) gnt_idx = VC_W'(v);
    end
  end

  always_comb begin
    if (busy_q) begin
      sel  = owner_q;
      fire = in_valid_i[owner_q] && has_one[owner_q];
    end else begin
      sel  = gnt_idx;
      fire = |gnt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (fire) begin
      if (in_tail_i[sel]) begin
        busy_q <= 1'b0;
      end else if (!busy_q) begin
        busy_q  <= 1'b1;
        owner_q <= sel;
      end
    end
  end

  assign in_ready_o  = send;
  assign out_valid_o = fire;
  assign out_vc_o    = sel;
  assign out_head_o  = fire && in_head_i[sel];
  assign out_tail_o  = fire && in_tail_i[sel];
  assign out_data_o  = in_data_i[sel];

  assert_head_only_when_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_head_o) |-> !busy_q);
  assert_cut_through_admit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_head_o && mode_i) |-> cnt[out_vc_o] >= CNT_W'(MAX_PKT));
  assert_send_matches_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (in_valid_i[out_vc_o] && $countones(in_ready_o) == 1));
  assert_idle_no_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o == '0);
endmodule

// File: tb/credit_vc_link_tx_tb.sv
`timescale 1ns/1ps
module credit_vc_link_tx_tb_top;
  localparam int NV = 4;
  localparam int FW = 16;
  localparam int VW = 2;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   mode = 1'b0;
  logic [NV-1:0]          in_valid = '0;
  logic [NV-1:0]          in_head = '0;
  logic [NV-1:0]          in_tail = '0;
  logic [NV-1:0][FW-1:0]  in_data = '0;
  logic [NV-1:0]          in_ready;
  logic                   out_valid;
  logic [VW-1:0]          out_vc;
  logic                   out_head;
  logic                   out_tail;
  logic [FW-1:0]          out_data;
  logic                   crd_valid = 1'b0;
  logic [VW-1:0]          crd_vc = '0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  credit_vc_link_tx #(.NUM_VC(NV), .FLIT_W(FW), .BUF_DEPTH(6), .MAX_PKT(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .in_valid_i(in_valid), .in_head_i(in_head), .in_tail_i(in_tail), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_vc_o(out_vc),
    .out_head_o(out_head), .out_tail_o(out_tail), .out_data_o(out_data),
    .crd_valid_i(crd_valid), .crd_vc_i(crd_vc)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_all();
    in_valid  = '0;
    in_head   = '0;
    in_tail   = '0;
    in_data   = '0;
    crd_valid = 1'b0;
  endtask

  task automatic put(int v, bit h, bit t, int d);
    in_valid[v] = 1'b1;
    in_head[v]  = h;
    in_tail[v]  = t;
    in_data[v]  = FW'(d);
  endtask

  task automatic give(int v);
    crd_valid = 1'b1;
    crd_vc    = VW'(v);
  endtask

  // sample 1 ns after the falling-edge drive, then move to the next falling edge
  task automatic step(string req, bit ev, int evc, int ed);
    #1;
    chk(req, "out_valid", int'(out_valid), int'(ev));
    if (ev) begin
      chk(req, "out_vc", int'(out_vc), evc);
      chk(req, "out_data", int'(out_data), ed);
      chk(req, "in_ready", int'(in_ready), 1 << evc);
      chk(req, "head/tail", {out_head, out_tail}, {in_head[evc], in_tail[evc]});
    end else begin
      chk(req, "in_ready idle", int'(in_ready), 0);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    idle_all();
    step("R1", 0, 0, 0);
  endtask

  // wormhole: VC0 drains, stalls mid-packet, resumes on credits
  task automatic t_wormhole();
    mode = 1'b0;
    for (int i = 0; i < 6; i++) begin
      idle_all(); put(0, i == 0, 0, 'h100 + i);
      step("R4", 1, 0, 'h100 + i);
    end
    for (int k = 0; k < 2; k++) begin
      idle_all(); put(0, 0, 0, 'h106); put(1, 1, 1, 'h201);
      step("R6", 0, 0, 0);
    end
    idle_all(); put(0, 0, 0, 'h106); put(1, 1, 1, 'h201); give(0);
    step("R3", 0, 0, 0);
    idle_all(); put(0, 0, 0, 'h106); put(1, 1, 1, 'h201); give(0);
    step("R3", 1, 0, 'h106);
    idle_all(); put(0, 0, 1, 'h107); put(1, 1, 1, 'h201);
    step("R7", 1, 0, 'h107);
    idle_all(); put(1, 1, 1, 'h201);
    step("R2", 1, 1, 'h201);
    idle_all(); put(0, 1, 1, 'h108);
    step("R1", 0, 0, 0);
    for (int k = 0; k < 6; k++) begin
      idle_all(); give(0);
      step("R3", 0, 0, 0);
    end
    idle_all(); give(1);
    step("R3", 0, 0, 0);
  endtask

  // cut-through versus wormhole admission on VC2
  task automatic t_cut_through();
    mode = 1'b0;
    idle_all(); put(2, 1, 0, 'h300); step("R4", 1, 2, 'h300);
    idle_all(); put(2, 0, 0, 'h301); step("R4", 1, 2, 'h301);
    idle_all(); put(2, 0, 1, 'h302); step("R4", 1, 2, 'h302);
    mode = 1'b1;
    for (int k = 0; k < 2; k++) begin
      idle_all(); put(2, 1, 1, 'h310);
      step("R5", 0, 0, 0);
    end
    mode = 1'b0;
    idle_all(); put(2, 1, 1, 'h310); step("R4", 1, 2, 'h310);
    mode = 1'b1;
    idle_all(); put(2, 1, 1, 'h311); give(2); step("R5", 0, 0, 0);
    idle_all(); put(2, 1, 1, 'h311); give(2); step("R5", 0, 0, 0);
    idle_all(); put(2, 1, 1, 'h311); step("R5", 1, 2, 'h311);
    for (int k = 0; k < 3; k++) begin
      idle_all(); give(2);
      step("R3", 0, 0, 0);
    end
    mode = 1'b0;
  endtask

  // last head granted was VC2, so the search starts at VC3
  task automatic t_round_robin();
    mode = 1'b0;
    for (int c = 0; c < 8; c++) begin
      int evc;
      evc = (3 + c) % NV;
      idle_all();
      for (int v = 0; v < NV; v++) put(v, 1, 1, 'h400 + v);
      step("R8", 1, evc, 'h400 + evc);
    end
  endtask

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wormhole();
    t_cut_through();
    t_round_robin();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule